// File: doc/BRIEF.md
# Interleaved Memory Range Decoder with Commit Handshake

This block decodes one host-managed address window for a memory expander endpoint. Software programs it through a 32-bit register port. The settings are a 64-bit window base, a 64-bit window length and a control word. The control word holds the interleave granularity (IG), the interleave way count (IW) and three handshake bits: COMMIT, COMMITTED and ERR. Writing the control word with COMMIT set starts a two-step handshake. The word is stored with COMMITTED low. One cycle later COMMIT and ERR self-clear and COMMITTED rises.

On the memory side the host issues one read or write per cycle with a host physical address. While the window is committed, an address inside it is turned into a device address. The translation keeps the offset bits below position 8+IG and drops the IW way-select bits that sit directly above them. The higher bits move down by IW places. The device address then selects a 64-bit word of a small internal RAM. The reply comes one cycle later as a strobe with an error flag and read data. Reads that miss are answered with an error. Writes that miss are dropped, but they are still answered as successful.

The handshake is run by a two-state machine:
- CM_IDLE: nothing is pending.
- CM_PENDING: a commit write has been stored and completion is due in the next cycle.

The machine has three transitions:
- CM_IDLE→CM_PENDING, on a control write with COMMIT set.
- CM_PENDING→CM_IDLE, when completion is applied.
- CM_PENDING→CM_PENDING, when a further commit write arrives and restarts completion.

Top module: `ilv_range_decoder`

## Requirements
- R1: After reset, every register reads 0 and no memory response is signalled.
- R2: Word offsets map as follows: 0 is control, 1 is base[31:0], 2 is base[63:32], 3 is length[31:0] and 4 is length[63:32]. These five read back what was written. Offsets 5 to 7 read 0 and ignore writes.
- R3: A register access at an offset of 8 or above raises cfg_err in the same cycle, reads 0 and changes no register.
- R4: A control write with bit 9 (COMMIT) set is stored as written, with bit 10 (COMMITTED) forced to 0. On the next clock, bits 9 and 11 (ERR) clear and bit 10 becomes 1. All other bits are kept.
- R5: A control write with bit 9 clear stores every bit except bit 10, which keeps its previous value.
- R6: While COMMITTED is 0, every memory access misses.
- R7: An address below the base misses. So does an address whose offset from the base is greater than or equal to the length.
- R8: The device address is built from the offset in two parts. Offset bits below position 8+IG are kept. Offset bits from position 8+IG+IW upward are shifted right by IW. IG is control bits [3:0] and IW is control bits [7:4].
- R9: Every memory request produces mem_rsp_valid in the next cycle. A read that hits returns the word stored at device address bits [..:3], with the error flag low.
- R10: A read that misses the window, or whose device address is at or beyond DEPTH*8 bytes, responds with the error flag high and data 0.
- R11: A write that misses, or that lies beyond the RAM, leaves the RAM unchanged and responds with the error flag low.
- R12: IG and IW are used live. Changing them with a control write that does not commit changes the translation at once, while the window stays committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_rd_en | input | 1 | Register read strobe |
| cfg_addr | input | CFG_AW | Register word offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid in the cycle of cfg_rd_en |
| cfg_err | output | 1 | Illegal register offset, in the cycle of the access |
| mem_req | input | 1 | Memory request strobe |
| mem_we | input | 1 | 1 = write, 0 = read |
| mem_addr | input | 64 | Host physical address |
| mem_wdata | input | 64 | Write data |
| mem_rsp_valid | output | 1 | Response strobe, one cycle after mem_req |
| mem_rsp_err | output | 1 | Read failed |
| mem_rsp_rdata | output | 64 | Read data |

## Verification
The hardest case to reach is showing that the translation is correct and not merely consistent. Writing to an address and reading the same address back would pass for any one-to-one mapping. The bench therefore keeps a reference RAM indexed by its own arithmetic device address. It writes at each offset of a sweep, then reads at a second host address that differs only in the lowest way-select bit. When IW is nonzero, that address must alias the word just written. When IW is zero, it must land on a different word. A second hard case is a write that falls beyond the RAM. Its truncated index would hit word 0, so word 0 is seeded first and read again afterwards.

// File: rtl/ilvdec_pkg.sv
package ilvdec_pkg;

    // control word field positions
    localparam int IG_LSB        = 0;
    localparam int IG_W          = 4;
    localparam int IW_LSB        = 4;
    localparam int IW_W          = 4;
    localparam int BIT_COMMIT    = 9;
    localparam int BIT_COMMITTED = 10;
    localparam int BIT_ERR       = 11;

    // register word offsets
    localparam int W_CTRL    = 0;
    localparam int W_BASE_LO = 1;
    localparam int W_BASE_HI = 2;
    localparam int W_SIZE_LO = 3;
    localparam int W_SIZE_HI = 4;

    typedef enum logic {
        CM_IDLE,
        CM_PENDING
    } commit_state_e;

    typedef struct packed {
        logic [63:0]     base;
        logic [63:0]     size;
        logic [IG_W-1:0] ig;
        logic [IW_W-1:0] iw;
        logic            committed;
    } window_cfg_t;

endpackage

// File: rtl/ilvdec_regs.sv
module ilvdec_regs
    import ilvdec_pkg::*;
#(
    parameter int CFG_AW    = 4,
    parameter int REG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [CFG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              err,
    output window_cfg_t       cfg
);
    localparam int IDX_W = $clog2(REG_WORDS);
    localparam logic [CFG_AW:0] LIMIT = (CFG_AW+1)'(REG_WORDS);

    logic [31:0]      ctrl_q;
    logic [63:0]      base_q;
    logic [63:0]      size_q;
    logic             legal;
    logic [IDX_W-1:0] idx;
    logic             ctrl_hit;
    logic             commit_req;
    logic [31:0]      ctrl_wr_val;
    commit_state_e    cm_state, cm_next;

    assign legal      = ({1'b0, addr} < LIMIT);
    assign idx        = addr[IDX_W-1:0];
    assign ctrl_hit   = wr_en && legal && (idx == IDX_W'(W_CTRL));
    assign commit_req = ctrl_hit && wdata[BIT_COMMIT];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) cm_state <= CM_IDLE;
        else        cm_state <= cm_next;
    end

    always_comb begin
        cm_next = cm_state;
        unique case (cm_state)
            CM_IDLE:    if (commit_req) cm_next = CM_PENDING;
            CM_PENDING: cm_next = commit_req ? CM_PENDING : CM_IDLE;
        endcase
    end

    always_comb begin
        ctrl_wr_val = wdata;
        ctrl_wr_val[BIT_COMMITTED] = commit_req ? 1'b0 : ctrl_q[BIT_COMMITTED];
    end

    // register updates driven by the state machine and the write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            base_q <= '0;
            size_q <= '0;
        end else begin
            if (ctrl_hit) begin
                ctrl_q <= ctrl_wr_val;
            end else if (cm_state == CM_PENDING) begin
                ctrl_q[BIT_COMMIT]    <= 1'b0;
                ctrl_q[BIT_ERR]       <= 1'b0;
                ctrl_q[BIT_COMMITTED] <= 1'b1;
            end
            if (wr_en && legal) begin
                case (idx)
                    IDX_W'(W_BASE_LO): base_q[31:0]  <= wdata;
                    IDX_W'(W_BASE_HI): base_q[63:32] <= wdata;
                    IDX_W'(W_SIZE_LO): size_q[31:0]  <= wdata;
                    IDX_W'(W_SIZE_HI): size_q[63:32] <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en && legal) begin
            case (idx)
                IDX_W'(W_CTRL):    rdata = ctrl_q;
                IDX_W'(W_BASE_LO): rdata = base_q[31:0];
                IDX_W'(W_BASE_HI): rdata = base_q[63:32];
                IDX_W'(W_SIZE_LO): rdata = size_q[31:0];
                IDX_W'(W_SIZE_HI): rdata = size_q[63:32];
                default:           rdata = '0;
            endcase
        end
    end

    assign err = (rd_en || wr_en) && !legal;

    assign cfg.base      = base_q;
    assign cfg.size      = size_q;
    assign cfg.ig        = ctrl_q[IG_LSB +: IG_W];
    assign cfg.iw        = ctrl_q[IW_LSB +: IW_W];
    assign cfg.committed = ctrl_q[BIT_COMMITTED];

    AST_COMMIT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> (!ctrl_q[BIT_COMMITTED] && ctrl_q[BIT_COMMIT])); // R4

    AST_COMMIT_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_state == CM_PENDING && !ctrl_hit) |=>
        (ctrl_q[BIT_COMMITTED] && !ctrl_q[BIT_COMMIT] && !ctrl_q[BIT_ERR])); // R4

    AST_ILLEGAL_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !legal && cm_state == CM_IDLE) |=>
        ($stable(ctrl_q) && $stable(base_q) && $stable(size_q))); // R3

endmodule

// File: rtl/ilvdec_xlate.sv
module ilvdec_xlate
    import ilvdec_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  window_cfg_t      cfg,
    input  logic [63:0]      hpa,
    output logic             ok,
    output logic [IDX_W-1:0] word_idx
);
    localparam logic [63:0] BYTES = 64'(DEPTH) * 64'd8;

    logic [63:0] off;
    logic [63:0] keep_mask;
    logic [63:0] dpa;
    logic [5:0]  low_w;
    logic [5:0]  high_sh;
    logic        in_win;
    logic        in_range;

    assign off       = hpa - cfg.base;
    assign in_win    = (hpa >= cfg.base) && (off < cfg.size);
    assign low_w     = 6'd8 + {2'b00, cfg.ig};
    assign high_sh   = low_w + {2'b00, cfg.iw};
    assign keep_mask = (64'd1 << low_w) - 64'd1;
    assign dpa       = (off & keep_mask) | ((off >> high_sh) << low_w);
    assign in_range  = dpa < BYTES;
    assign ok        = cfg.committed && in_win && in_range;
    assign word_idx  = dpa[IDX_W+2:3];

    always_comb begin
        if (in_win) begin
            AST_DPA_NOT_ABOVE_OFF: assert (dpa <= off); // R8
        end
    end

endmodule

// File: rtl/ilvdec_mem.sv
module ilvdec_mem #(
    parameter int DEPTH = 64,
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             we,
    input  logic             ok,
    input  logic [IDX_W-1:0] idx,
    input  logic [63:0]      wdata,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic [63:0]      rsp_rdata
);
    logic [63:0] ram [DEPTH];

    always_ff @(posedge clk) begin
        if (req && we && ok) ram[idx] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req;
            rsp_err   <= req && !we && !ok;
            rsp_rdata <= (req && !we && ok) ? ram[idx] : 64'd0;
        end
    end

    AST_WRITE_NEVER_ERRS: assert property (@(posedge clk) disable iff (!rst_n)
        (req && we) |=> !rsp_err); // R11

    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 64'd0)); // R10

endmodule

// File: rtl/ilv_range_decoder.sv
module ilv_range_decoder
    import ilvdec_pkg::*;
#(
    parameter int CFG_AW    = 4,
    parameter int REG_WORDS = 8,
    parameter int DEPTH     = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_rd_en,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              cfg_err,
    input  logic              mem_req,
    input  logic              mem_we,
    input  logic [63:0]       mem_addr,
    input  logic [63:0]       mem_wdata,
    output logic              mem_rsp_valid,
    output logic              mem_rsp_err,
    output logic [63:0]       mem_rsp_rdata
);
    localparam int IDX_W = $clog2(DEPTH);

    window_cfg_t      win_cfg;
    logic             acc_ok;
    logic [IDX_W-1:0] acc_idx;

    ilvdec_regs #(.CFG_AW(CFG_AW), .REG_WORDS(REG_WORDS)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (cfg_wr_en),
        .rd_en (cfg_rd_en),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .err   (cfg_err),
        .cfg   (win_cfg)
    );

    ilvdec_xlate #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_xlate (
        .cfg      (win_cfg),
        .hpa      (mem_addr),
        .ok       (acc_ok),
        .word_idx (acc_idx)
    );

    ilvdec_mem #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (mem_req),
        .we        (mem_we),
        .ok        (acc_ok),
        .idx       (acc_idx),
        .wdata     (mem_wdata),
        .rsp_valid (mem_rsp_valid),
        .rsp_err   (mem_rsp_err),
        .rsp_rdata (mem_rsp_rdata)
    );

    AST_RSP_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> mem_rsp_valid); // R9

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |=> !mem_rsp_valid); // R9

    AST_UNCOMMITTED_READ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !win_cfg.committed) |=> mem_rsp_err); // R6

endmodule

// File: tb/ilv_range_decoder_bench.sv
module ilv_range_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0, cfg_rd_en = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        cfg_err;
    logic        mem_req = 1'b0, mem_we = 1'b0;
    logic [63:0] mem_addr = '0, mem_wdata = '0;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [63:0] mem_rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic last_wr_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    ilv_range_decoder #(.CFG_AW(4), .REG_WORDS(8), .DEPTH(DEPTH)) u_ilv_range_decoder (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cfg_err(cfg_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err), .mem_rsp_rdata(mem_rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
        #1 last_wr_err = cfg_err;
        @(posedge clk); #1;
        cfg_wr_en = 1'b0;
    endtask

    task automatic cfg_read(input logic [3:0] a, output logic [31:0] d, output logic e);
        cfg_rd_en = 1'b1; cfg_addr = a;
        #1 d = cfg_rdata; e = cfg_err;
        cfg_rd_en = 1'b0;
    endtask

    task automatic mem_access(input logic we, input logic [63:0] a, input logic [63:0] d,
                              output logic v, output logic e, output logic [63:0] r);
        @(posedge clk); #1;
        mem_req = 1'b1; mem_we = we; mem_addr = a; mem_wdata = d;
        @(posedge clk); #1;
        mem_req = 1'b0;
        v = mem_rsp_valid; e = mem_rsp_err; r = mem_rsp_rdata;
    endtask

    task automatic set_window(input logic [63:0] b, input logic [63:0] s);
        cfg_write(4'd1, b[31:0]);  cfg_write(4'd2, b[63:32]);
        cfg_write(4'd3, s[31:0]);  cfg_write(4'd4, s[63:32]);
    endtask

    function automatic longint unsigned exp_dpa(longint unsigned off, int ig, int iw);
        longint unsigned g = 64'd1 << (8 + ig);
        return (off % g) + (off / (g << iw)) * g;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic e, v;
        logic [63:0] r;
        logic [63:0] mirror [DEPTH];
        bit vld [DEPTH];
        logic [63:0] base;
        logic [63:0] seed;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk(mem_rsp_valid == 1'b0, "R1 rsp idle", {63'd0, mem_rsp_valid}, 64'd0);
        for (int i = 0; i < 5; i++) begin
            cfg_read(4'(i), rd, e);
            chk(rd == 32'd0 && !e, "R1 reg zero", {32'd0, rd}, 64'd0);
        end

        // R2: map readback and reserved words
        set_window(64'h1234_5678_9ABC_DEF0, 64'h0FED_CBA9_8765_4321);
        cfg_read(4'd1, rd, e); chk(rd == 32'h9ABC_DEF0, "R2 base lo", {32'd0, rd}, 64'h9ABC_DEF0);
        cfg_read(4'd2, rd, e); chk(rd == 32'h1234_5678, "R2 base hi", {32'd0, rd}, 64'h1234_5678);
        cfg_read(4'd3, rd, e); chk(rd == 32'h8765_4321, "R2 size lo", {32'd0, rd}, 64'h8765_4321);
        cfg_read(4'd4, rd, e); chk(rd == 32'h0FED_CBA9, "R2 size hi", {32'd0, rd}, 64'h0FED_CBA9);
        cfg_write(4'd6, 32'hFFFF_FFFF);
        cfg_read(4'd6, rd, e); chk(rd == 32'd0 && !e, "R2 reserved", {32'd0, rd}, 64'd0);

        // R3: illegal offsets
        cfg_read(4'd8, rd, e); chk(e && rd == 32'd0, "R3 illegal read", {31'd0, e, rd}, 64'h1_0000_0000);
        cfg_write(4'd12, 32'hAAAA_5555);
        chk(last_wr_err == 1'b1, "R3 illegal write err", {63'd0, last_wr_err}, 64'd1);
        cfg_read(4'd1, rd, e); chk(rd == 32'h9ABC_DEF0, "R3 no change", {32'd0, rd}, 64'h9ABC_DEF0);
        cfg_read(4'd4, rd, e); chk(rd == 32'h0FED_CBA9, "R3 no change hi", {32'd0, rd}, 64'h0FED_CBA9);

        // R6 / R5: uncommitted window misses; COMMITTED not software-writable
        set_window(64'd0, 64'h1000);
        cfg_write(4'd0, 32'h0000_0400);
        cfg_read(4'd0, rd, e); chk(rd == 32'd0, "R5 committed not writable", {32'd0, rd}, 64'd0);
        mem_access(1'b1, 64'h10, 64'h55, v, e, r);
        mem_access(1'b0, 64'h10, 64'd0, v, e, r);
        chk(v && e && r == 64'd0, "R6 uncommitted read", {62'd0, v, e}, 64'd3);

        // R4: commit handshake
        cfg_write(4'd0, 32'h0000_0A21);
        cfg_read(4'd0, rd, e); chk(rd == 32'h0000_0A21, "R4 stored committed low", {32'd0, rd}, 64'hA21);
        @(posedge clk); #1;
        cfg_read(4'd0, rd, e); chk(rd == 32'h0000_0421, "R4 completed", {32'd0, rd}, 64'h421);
        // R5: non-commit write keeps COMMITTED
        cfg_write(4'd0, 32'h0000_0013);
        cfg_read(4'd0, rd, e); chk(rd == 32'h0000_0413, "R5 kept", {32'd0, rd}, 64'h413);

        // R8 / R9 / R10 / R12: sweep over IG and IW, changed live without recommit
        base = 64'h1_0000_0000;
        set_window(base, 64'h1000);
        for (int ig = 0; ig < 2; ig++) begin
            for (int iw = 0; iw < 3; iw++) begin
                cfg_write(4'd0, 32'((iw << 4) | ig));
                for (int k = 0; k < DEPTH; k++) vld[k] = 0;
                for (longint unsigned off = 0; off < 64'h1000; off += 40) begin
                    longint unsigned d1 = exp_dpa(off, ig, iw);
                    longint unsigned off2 = off ^ (64'd1 << (8 + ig));
                    longint unsigned d2;
                    logic [63:0] data = {24'hA5A5A5, 4'(ig), 4'(iw), 32'(off)};
                    if (off2 >= 64'h1000) off2 = off;
                    d2 = exp_dpa(off2, ig, iw);
                    mem_access(1'b1, base + off, data, v, e, r);
                    chk(v && !e, "R11 write rsp ok", {62'd0, v, e}, 64'd2);
                    if (d1 < DEPTH * 8) begin
                        mirror[d1 >> 3] = data;
                        vld[d1 >> 3] = 1;
                    end
                    mem_access(1'b0, base + off2, 64'd0, v, e, r);
                    if (d2 >= DEPTH * 8) begin
                        chk(v && e && r == 64'd0, "R10 beyond ram read", r, 64'd0);
                    end else if (vld[d2 >> 3]) begin
                        chk(v && !e && r == mirror[d2 >> 3], "R8 R9 R12 translated read",
                            r, mirror[d2 >> 3]);
                    end else begin
                        chk(v && !e, "R9 hit no err", {62'd0, v, e}, 64'd2);
                    end
                end
            end
        end

        // R7: window edges (IG=0, IW=0)
        cfg_write(4'd0, 32'h0);
        set_window(64'h2000, 64'h100);
        mem_access(1'b0, 64'h1FF8, 64'd0, v, e, r);
        chk(v && e, "R7 below base", {62'd0, v, e}, 64'd3);
        mem_access(1'b1, 64'h20F8, 64'hCAFE_0001, v, e, r);
        mem_access(1'b0, 64'h20F8, 64'd0, v, e, r);
        chk(v && !e && r == 64'hCAFE_0001, "R7 last word hit", r, 64'hCAFE_0001);
        mem_access(1'b0, 64'h2100, 64'd0, v, e, r);
        chk(v && e && r == 64'd0, "R7 R10 at end miss", r, 64'd0);

        // R11: dropped writes leave RAM unchanged
        seed = 64'h0BAD_F00D_1234_0000;
        mem_access(1'b1, 64'h2000, seed, v, e, r);
        mem_access(1'b1, 64'h2100, 64'h1111, v, e, r);
        chk(v && !e, "R11 window miss write ok", {62'd0, v, e}, 64'd2);
        mem_access(1'b1, 64'h1000, 64'h2222, v, e, r);
        chk(v && !e, "R11 below base write ok", {62'd0, v, e}, 64'd2);
        set_window(64'h2000, 64'h10000);
        mem_access(1'b1, 64'h3000, 64'h3333, v, e, r);
        chk(v && !e, "R11 beyond ram write ok", {62'd0, v, e}, 64'd2);
        mem_access(1'b0, 64'h2000, 64'd0, v, e, r);
        chk(v && !e && r == seed, "R11 word0 unchanged", r, seed);
        mem_access(1'b0, 64'h20F8, 64'd0, v, e, r);
        chk(r == 64'hCAFE_0001, "R11 last word unchanged", r, 64'hCAFE_0001);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule